// File: doc/BRIEF.md
# SDRAM Command Controller with Refresh

This block sits between a host and a four-bank synchronous DRAM and turns single access requests into a legal stream of memory commands. After reset it waits a programmable settling time with the chip deselected. It then precharges every bank, issues one auto refresh and writes the mode word, which holds CAS latency, burst length and burst type. Only after that does it accept requests.

Each request carries a bank, a row, a column, a read/write flag and an auto-precharge flag. The controller remembers which row is open in each bank:
- On a row hit it sends the column command at once.
- On a closed bank it activates the row first.
- On a row conflict it precharges that bank, activates the new row and then sends the column command.

Activate-to-column and precharge-to-activate spacing are kept at their minimum clock counts. A free-running interval timer spreads 8192 refreshes over 64 ms. When the timer expires, the pending refresh beats any new host request. Open banks are precharged together before the refresh command is sent.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While reset is asserted the chip-select output is high and the clock-enable output low. The clock enable rises one clock after reset is released. Chip select stays high (deselect) and `reqReady` stays low until INIT_CYCLES clocks have elapsed.
- R2: The first three commands after the settling time are, in this order: precharge-all (address bit 10 high), auto refresh, and mode register set with address equal to MODE_WORD and bank 0. No request is accepted before the mode set.
- R3: Commands are encoded as {csN,rasN,casN,weN}:
  - activate 0011
  - read 0101
  - write 0100
  - precharge 0010
  - auto refresh 0001
  - mode set 0000
  - no-op 0111
  - deselect 1xxx

  No other code is ever driven.
- R4: The host address is {bank[24:23], row[22:10], column[9:0]}. An activate drives the row on the memory address and the bank on the bank output.
- R5: A read or write drives the column on address bits 9:0 and the bank on the bank output. When it follows an activate it comes exactly T_RCD clocks after it, and never sooner than T_RCD after the last activate to that bank.
- R6: A request to the row already open in its bank produces only the column command, with no activate or precharge. A column command is never sent to a closed bank.
- R7: A request to a bank holding a different row produces a single-bank precharge (address bit 10 low) and then an activate. An activate is never sent to an open bank, and never sooner than T_RP clocks after that bank was precharged.
- R8: Address bit 10 of a read or write equals the request's auto-precharge flag. The bank is then treated as closed: the next access to it activates without a precharge, no sooner than COL_GAP+T_RP clocks after the column command.
- R9: An auto refresh is issued only with all banks closed and at least T_RP after the last precharge. Periodic refreshes occur every 64000*CLK_MHZ/8192 clocks, within a bounded service delay.
- R10: A pending refresh takes priority over host requests. The refresh spacing holds even under continuous host traffic.
- R11: `reqDone` is high in exactly those clocks in which a read or write command is on the memory pins.
- R12: After a read or write, at least COL_GAP clocks pass before any further command.
- R13: The clock-enable output stays high whenever a command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAutoPre | input | 1 | Close the bank after this access |
| reqAddr | input | 25 | {bank, row, column} |
| reqReady | output | 1 | Request taken on this clock if reqValid |
| reqDone | output | 1 | Column command issued this clock |
| memCke | output | 1 | Memory clock enable |
| memCsN | output | 1 | Chip select, active low |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memBa | output | 2 | Bank select |
| memAddr | output | 13 | Multiplexed row/column/mode address |

## Verification
A stale open-row entry shows at the pins as soon as the next request reaches that bank. It appears as a missing precharge, a spurious activate, or an activate sent into an open bank, all visible within the request's own two to three commands. A wait counter loaded with the wrong value shows as a column command or activate arriving one clock early or late relative to the command it depends on. A fault in the refresh timer or its priority shows within one refresh interval: the gap between refresh commands drifts out of its window, or a refresh is issued while a bank model still holds an open row.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  localparam int WAIT_W = 6;

  typedef enum logic [3:0] {
    CMD_DESEL, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR,
    CMD_PRE, CMD_PREALL, CMD_REF, CMD_MRS
  } memCmd_t;

  // Strobes from control to datapath
  typedef struct packed {
    memCmd_t           cmd;
    logic              loadReq;
    logic              loadWait;
    logic [WAIT_W-1:0] waitLen;
  } ctlStrobe_t;
endpackage

// File: rtl/sdram_cmd_datapath.sv
module sdram_cmd_datapath
  import sdram_cmd_pkg::*;
#(
  parameter int ROW_W        = 13,
  parameter int COL_W        = 10,
  parameter int BANK_W       = 2,
  parameter int INIT_CYCLES  = 20000,
  parameter int REF_INTERVAL = 781,
  parameter logic [ROW_W-1:0] MODE_WORD = 13'h032,
  parameter int T_RCD        = 2,
  parameter int T_RP         = 2,
  parameter int T_RFC        = 7,
  parameter int T_MRD        = 2,
  parameter int COL_GAP      = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctlStrobe_t                      strobe,
  input  logic                            reqWrite,
  input  logic                            reqAutoPre,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   reqAddr,
  output logic                            initDone,
  output logic                            refreshDue,
  output logic                            waitDone,
  output logic                            bankOpen,
  output logic                            rowHit,
  output logic                            anyOpen,
  output logic                            reqIsWrite,
  output logic                            reqIsAutoPre,
  output logic                            reqDone,
  output logic                            memCke,
  output logic                            memCsN,
  output logic                            memRasN,
  output logic                            memCasN,
  output logic                            memWeN,
  output logic [BANK_W-1:0]               memBa,
  output logic [ROW_W-1:0]                memAddr
);
  localparam int BANKS   = 1 << BANK_W;
  localparam int AP_BIT  = 10;
  localparam int INIT_W  = $clog2(INIT_CYCLES + 1);
  localparam int REF_W   = $clog2(REF_INTERVAL);
  localparam int SAT_W   = 6;
  localparam int DUE_LIMIT = 3 * T_RP + T_RCD + COL_GAP + T_RFC + T_MRD + 8;

  // Latched request
  logic [BANK_W-1:0] reqBank;
  logic [ROW_W-1:0]  reqRow;
  logic [COL_W-1:0]  reqCol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqBank <= '0; reqRow <= '0; reqCol <= '0;
      reqIsWrite <= 1'b0; reqIsAutoPre <= 1'b0;
    end else if (strobe.loadReq) begin
      {reqBank, reqRow, reqCol} <= reqAddr;
      reqIsWrite   <= reqWrite;
      reqIsAutoPre <= reqAutoPre;
    end
  end

  // Open-row tracking, one entry per bank
  logic [BANKS-1:0] openValid;
  logic [ROW_W-1:0] openRow [BANKS];

  for (genvar g = 0; g < BANKS; g++) begin : gBank
    logic             validQ;
    logic [ROW_W-1:0] rowQ;
    logic             selThis;
    assign selThis = (reqBank == BANK_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ <= 1'b0;
        rowQ   <= '0;
      end else begin
        case (strobe.cmd)
          CMD_ACT:        if (selThis) begin validQ <= 1'b1; rowQ <= reqRow; end
          CMD_PRE:        if (selThis) validQ <= 1'b0;
          CMD_PREALL:     validQ <= 1'b0;
          CMD_RD, CMD_WR: if (selThis && reqIsAutoPre) validQ <= 1'b0;
          default: ;
        endcase
      end
    end
    assign openValid[g] = validQ;
    assign openRow[g]   = rowQ;
  end

  assign bankOpen = openValid[reqBank];
  assign rowHit   = bankOpen && (openRow[reqBank] == reqRow);
  assign anyOpen  = |openValid;

  // Spacing counter
  logic [WAIT_W-1:0] waitCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                waitCnt <= '0;
    else if (strobe.loadWait) waitCnt <= strobe.waitLen - WAIT_W'(2);
    else if (waitCnt != '0)   waitCnt <= waitCnt - WAIT_W'(1);
  end
  assign waitDone = (waitCnt == '0);

  // Settling time after reset
  logic [INIT_W-1:0] initCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          initCnt <= '0;
    else if (!initDone) initCnt <= initCnt + INIT_W'(1);
  end
  assign initDone = (initCnt == INIT_W'(INIT_CYCLES));

  // Refresh interval timer
  logic [REF_W-1:0] refCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt <= '0;
      refreshDue <= 1'b0;
    end else if (initDone) begin
      if (refCnt == REF_W'(REF_INTERVAL - 1)) begin
        refCnt <= '0;
        refreshDue <= 1'b1;
      end else begin
        refCnt <= refCnt + REF_W'(1);
        if (strobe.cmd == CMD_REF) refreshDue <= 1'b0;
      end
    end
  end

  // Address and bank for the next command
  logic [ROW_W-1:0]  nextAddr;
  logic [BANK_W-1:0] nextBa;
  always_comb begin
    nextAddr = '0;
    nextBa   = '0;
    case (strobe.cmd)
      CMD_ACT: begin nextAddr = reqRow; nextBa = reqBank; end
      CMD_RD, CMD_WR: begin
        nextAddr[COL_W-1:0] = reqCol;
        nextAddr[AP_BIT]    = reqIsAutoPre;
        nextBa              = reqBank;
      end
      CMD_PRE:    nextBa = reqBank;
      CMD_PREALL: nextAddr[AP_BIT] = 1'b1;
      CMD_MRS:    nextAddr = MODE_WORD;
      default: ;
    endcase
  end

  memCmd_t cmdQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ <= CMD_DESEL; memAddr <= '0; memBa <= '0; memCke <= 1'b0;
    end else begin
      cmdQ <= strobe.cmd; memAddr <= nextAddr; memBa <= nextBa; memCke <= 1'b1;
    end
  end

  always_comb begin
    case (cmdQ)
      CMD_NOP:             {memCsN, memRasN, memCasN, memWeN} = 4'b0111;
      CMD_ACT:             {memCsN, memRasN, memCasN, memWeN} = 4'b0011;
      CMD_RD:              {memCsN, memRasN, memCasN, memWeN} = 4'b0101;
      CMD_WR:              {memCsN, memRasN, memCasN, memWeN} = 4'b0100;
      CMD_PRE, CMD_PREALL: {memCsN, memRasN, memCasN, memWeN} = 4'b0010;
      CMD_REF:             {memCsN, memRasN, memCasN, memWeN} = 4'b0001;
      CMD_MRS:             {memCsN, memRasN, memCasN, memWeN} = 4'b0000;
      default:             {memCsN, memRasN, memCasN, memWeN} = 4'b1111;
    endcase
  end
  assign reqDone = (cmdQ == CMD_RD) || (cmdQ == CMD_WR);

  // Timing observers used by the assertions below
  logic [SAT_W-1:0] sinceAct, sincePre, sinceCol;
  logic [7:0]       dueAge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceAct <= '1; sincePre <= '1; sinceCol <= '1; dueAge <= '0;
    end else begin
      sinceAct <= (cmdQ == CMD_ACT) ? SAT_W'(1) : ((&sinceAct) ? sinceAct : sinceAct + SAT_W'(1));
      sincePre <= (cmdQ == CMD_PRE || cmdQ == CMD_PREALL) ? SAT_W'(1)
                  : ((&sincePre) ? sincePre : sincePre + SAT_W'(1));
      sinceCol <= reqDone ? SAT_W'(1) : ((&sinceCol) ? sinceCol : sinceCol + SAT_W'(1));
      dueAge   <= refreshDue ? ((&dueAge) ? dueAge : dueAge + 8'd1) : 8'd0;
    end
  end

  a_r1_desel_until_init: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |=> (cmdQ == CMD_DESEL));
  a_r5_act_to_col: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |-> (sinceAct >= SAT_W'(T_RCD)));
  a_r7_pre_to_act: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_ACT) |-> (sincePre >= SAT_W'(T_RP)));
  a_r12_col_gap: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ != CMD_NOP && cmdQ != CMD_DESEL) |-> (sinceCol >= SAT_W'(COL_GAP)));
  a_r10_due_bounded: assert property (@(posedge clk) disable iff (!rstN)
    refreshDue |-> (dueAge < 8'(DUE_LIMIT)));
endmodule

// File: rtl/sdram_cmd_fsm.sv
module sdram_cmd_fsm
  import sdram_cmd_pkg::*;
#(
  parameter int T_RCD   = 2,
  parameter int T_RP    = 2,
  parameter int T_RFC   = 7,
  parameter int T_MRD   = 2,
  parameter int COL_GAP = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       initDone,
  input  logic       refreshDue,
  input  logic       waitDone,
  input  logic       bankOpen,
  input  logic       rowHit,
  input  logic       anyOpen,
  input  logic       reqIsWrite,
  input  logic       reqIsAutoPre,
  output logic       reqReady,
  output ctlStrobe_t strobe
);
  localparam logic [WAIT_W-1:0] W_RCD  = WAIT_W'(T_RCD);
  localparam logic [WAIT_W-1:0] W_RP   = WAIT_W'(T_RP);
  localparam logic [WAIT_W-1:0] W_RFC  = WAIT_W'(T_RFC);
  localparam logic [WAIT_W-1:0] W_MRD  = WAIT_W'(T_MRD);
  localparam logic [WAIT_W-1:0] W_COL  = WAIT_W'(COL_GAP);
  localparam logic [WAIT_W-1:0] W_COLP = WAIT_W'(COL_GAP + T_RP);

  typedef enum logic [2:0] {
    S_INIT, S_INIT_REF, S_MRS, S_IDLE, S_ACCESS, S_REF, S_WAIT
  } state_t;

  state_t state, stateN, retState, retStateN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_INIT; retState <= S_IDLE;
    end else begin
      state <= stateN; retState <= retStateN;
    end
  end

  assign reqReady = (state == S_IDLE) && !refreshDue;

  always_comb begin
    stateN    = state;
    retStateN = retState;
    strobe    = '{cmd: CMD_NOP, loadReq: 1'b0, loadWait: 1'b0, waitLen: '0};
    case (state)
      S_INIT: begin
        strobe.cmd = CMD_DESEL;
        if (initDone) begin
          strobe = '{cmd: CMD_PREALL, loadReq: 1'b0, loadWait: 1'b1, waitLen: W_RP};
          stateN = S_WAIT; retStateN = S_INIT_REF;
        end
      end
      S_INIT_REF: begin
        strobe = '{cmd: CMD_REF, loadReq: 1'b0, loadWait: 1'b1, waitLen: W_RFC};
        stateN = S_WAIT; retStateN = S_MRS;
      end
      S_MRS: begin
        strobe = '{cmd: CMD_MRS, loadReq: 1'b0, loadWait: 1'b1, waitLen: W_MRD};
        stateN = S_WAIT; retStateN = S_IDLE;
      end
      S_IDLE: begin
        if (refreshDue) begin
          if (anyOpen) begin
            strobe = '{cmd: CMD_PREALL, loadReq: 1'b0, loadWait: 1'b1, waitLen: W_RP};
            stateN = S_WAIT; retStateN = S_REF;
          end else begin
            strobe = '{cmd: CMD_REF, loadReq: 1'b0, loadWait: 1'b1, waitLen: W_RFC};
            stateN = S_WAIT; retStateN = S_IDLE;
          end
        end else if (reqValid) begin
          strobe.loadReq = 1'b1;
          stateN = S_ACCESS;
        end
      end
      S_ACCESS: begin
        if (rowHit) begin
          strobe = '{cmd: reqIsWrite ? CMD_WR : CMD_RD, loadReq: 1'b0, loadWait: 1'b1,
                     waitLen: reqIsAutoPre ? W_COLP : W_COL};
          stateN = S_WAIT; retStateN = S_IDLE;
        end else if (bankOpen) begin
          strobe = '{cmd: CMD_PRE, loadReq: 1'b0, loadWait: 1'b1, waitLen: W_RP};
          stateN = S_WAIT; retStateN = S_ACCESS;
        end else begin
          strobe = '{cmd: CMD_ACT, loadReq: 1'b0, loadWait: 1'b1, waitLen: W_RCD};
          stateN = S_WAIT; retStateN = S_ACCESS;
        end
      end
      S_REF: begin
        strobe = '{cmd: CMD_REF, loadReq: 1'b0, loadWait: 1'b1, waitLen: W_RFC};
        stateN = S_WAIT; retStateN = S_IDLE;
      end
      S_WAIT: if (waitDone) stateN = retState;
      default: stateN = S_INIT;
    endcase
  end

  // R9: refresh only with all banks closed
  a_r9_ref_banks_closed: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cmd == CMD_REF) |-> !anyOpen);
endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
#(
  parameter int ROW_W       = 13,
  parameter int COL_W       = 10,
  parameter int BANK_W      = 2,
  parameter int CLK_MHZ     = 100,
  parameter int WINDOW_US   = 64000,
  parameter int REF_COUNT   = 8192,
  parameter int INIT_CYCLES = 20000,
  parameter logic [ROW_W-1:0] MODE_WORD = 13'h032,
  parameter int T_RCD       = 2,
  parameter int T_RP        = 2,
  parameter int T_RFC       = 7,
  parameter int T_MRD       = 2,
  parameter int COL_GAP     = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic                          reqWrite,
  input  logic                          reqAutoPre,
  input  logic [BANK_W+ROW_W+COL_W-1:0] reqAddr,
  output logic                          reqReady,
  output logic                          reqDone,
  output logic                          memCke,
  output logic                          memCsN,
  output logic                          memRasN,
  output logic                          memCasN,
  output logic                          memWeN,
  output logic [BANK_W-1:0]             memBa,
  output logic [ROW_W-1:0]              memAddr
);
  localparam int REF_INTERVAL = (WINDOW_US * CLK_MHZ) / REF_COUNT;

  ctlStrobe_t strobe;
  logic initDone, refreshDue, waitDone, bankOpen, rowHit, anyOpen;
  logic reqIsWrite, reqIsAutoPre;

  sdram_cmd_fsm #(
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .COL_GAP(COL_GAP)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .initDone(initDone),
    .refreshDue(refreshDue), .waitDone(waitDone), .bankOpen(bankOpen),
    .rowHit(rowHit), .anyOpen(anyOpen), .reqIsWrite(reqIsWrite),
    .reqIsAutoPre(reqIsAutoPre), .reqReady(reqReady), .strobe(strobe)
  );

  sdram_cmd_datapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .INIT_CYCLES(INIT_CYCLES),
    .REF_INTERVAL(REF_INTERVAL), .MODE_WORD(MODE_WORD), .T_RCD(T_RCD),
    .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .COL_GAP(COL_GAP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqAutoPre(reqAutoPre), .reqAddr(reqAddr), .initDone(initDone),
    .refreshDue(refreshDue), .waitDone(waitDone), .bankOpen(bankOpen),
    .rowHit(rowHit), .anyOpen(anyOpen), .reqIsWrite(reqIsWrite),
    .reqIsAutoPre(reqIsAutoPre), .reqDone(reqDone), .memCke(memCke),
    .memCsN(memCsN), .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN),
    .memBa(memBa), .memAddr(memAddr)
  );
endmodule

// File: tb/sdram_cmd_ctrl_tb.sv
module sdram_cmd_ctrl_tb;
  localparam int T_RCD = 2, T_RP = 2, T_RFC = 7, T_MRD = 2, COL_GAP = 4;
  localparam int INIT = 20, CLK_MHZ = 32;
  localparam int REF_I = (64000 * CLK_MHZ) / 8192;
  localparam int SLACK = 40;
  localparam logic [12:0] MODE = 13'h032;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqAutoPre = 1'b0;
  logic [24:0] reqAddr = '0;
  logic reqReady, reqDone, memCke, memCsN, memRasN, memCasN, memWeN;
  logic [1:0] memBa;
  logic [12:0] memAddr;

  sdram_cmd_ctrl #(.CLK_MHZ(CLK_MHZ), .INIT_CYCLES(INIT), .MODE_WORD(MODE),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .COL_GAP(COL_GAP)
  ) u_dut (.*);

  always #2 clk = ~clk;

  int vectors = 0, fails = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic void check(bit ok, string req, string what, longint act, longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  // Bench model of the memory state, updated from observed pins
  logic [3:0]  openV = '0;
  logic [12:0] openR [4];
  int lastAct [4], lastPre [4];
  int lastColCyc = -1000, lastRefCyc = 0, refCount = 0, cmdIdx = 0;
  bit seenPre, seenAct;
  int actCyc;
  logic [12:0] actRow;
  initial for (int i = 0; i < 4; i++) begin lastAct[i] = -1000; lastPre[i] = -1000; openR[i] = '0; end

  always @(negedge clk) begin : monitor
    logic [3:0] code;
    bit isCol;
    int b;
    if (rstN) begin
      code  = {memCsN, memRasN, memCasN, memWeN};
      isCol = (code == 4'b0101) || (code == 4'b0100);
      b     = int'(memBa);
      if (reqDone || isCol) check(reqDone == isCol, "R11", "done vs column cmd", reqDone, isCol);
      if (!memCsN && code != 4'b0111) begin
        check(memCke, "R13", "cke at command", memCke, 1);
        check(code inside {4'b0011, 4'b0101, 4'b0100, 4'b0010, 4'b0001, 4'b0000},
              "R3", "legal encoding", code, 0);
        check(cyc - lastColCyc >= COL_GAP, "R12", "gap after column", cyc - lastColCyc, COL_GAP);
        if (cmdIdx == 0) check(code == 4'b0010 && memAddr[10], "R2", "first cmd precharge-all", code, 4'b0010);
        if (cmdIdx == 1) check(code == 4'b0001, "R2", "second cmd refresh", code, 4'b0001);
        if (cmdIdx == 2) check(code == 4'b0000 && memAddr == MODE && memBa == 0, "R2", "mode set word", memAddr, MODE);
        case (code)
          4'b0011: begin
            check(!openV[b], "R7", "activate to closed bank", openV[b], 0);
            check(cyc - lastPre[b] >= T_RP, "R7", "precharge to activate", cyc - lastPre[b], T_RP);
            openV[b] = 1'b1; openR[b] = memAddr; lastAct[b] = cyc;
            seenAct = 1; actCyc = cyc; actRow = memAddr;
          end
          4'b0101, 4'b0100: begin
            check(openV[b], "R6", "column to open bank", openV[b], 1);
            check(cyc - lastAct[b] >= T_RCD, "R5", "activate to column", cyc - lastAct[b], T_RCD);
            lastColCyc = cyc;
            if (memAddr[10]) begin openV[b] = 1'b0; lastPre[b] = cyc + COL_GAP; end
          end
          4'b0010: begin
            if (memAddr[10]) begin
              openV = '0;
              for (int i = 0; i < 4; i++) lastPre[i] = cyc;
            end else begin
              openV[b] = 1'b0; lastPre[b] = cyc; seenPre = 1;
            end
          end
          4'b0001: begin
            check(openV == 0, "R9", "refresh with banks closed", openV, 0);
            for (int i = 0; i < 4; i++)
              check(cyc - lastPre[i] >= T_RP, "R9", "precharge to refresh", cyc - lastPre[i], T_RP);
            if (refCount >= 2) begin
              check(cyc - lastRefCyc <= REF_I + SLACK, "R10", "refresh gap max", cyc - lastRefCyc, REF_I);
              check(cyc - lastRefCyc >= REF_I - SLACK, "R9", "refresh gap min", cyc - lastRefCyc, REF_I);
            end
            lastRefCyc = cyc; refCount++;
          end
          default: ;
        endcase
        cmdIdx++;
      end
    end
  end

  task automatic doReq(input int b, input int row, input int col, input bit wr, input bit ap);
    bit expHit, expMiss;
    int n;
    @(negedge clk);
    n = 0;
    while (!reqReady && n < 400) begin @(negedge clk); n++; end
    expHit  = openV[b] && (openR[b] == 13'(row));
    expMiss = openV[b] && !expHit;
    seenPre = 0; seenAct = 0;
    reqValid = 1'b1; reqWrite = wr; reqAutoPre = ap;
    reqAddr = {2'(b), 13'(row), 10'(col)};
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (!reqDone && n < 200) begin @(negedge clk); n++; end
    if (!reqDone) begin
      check(0, "R11", "request never completed", 0, 1);
      return;
    end
    check(memBa == 2'(b), "R4", "column bank", memBa, b);
    check(memAddr[9:0] == 10'(col), "R5", "column address", memAddr[9:0], col);
    check(memAddr[10] == ap, "R8", "auto-precharge bit", memAddr[10], ap);
    check(memWeN == !wr, "R3", "read/write encoding", memWeN, !wr);
    check(seenPre == expMiss, "R7", "conflict precharge", seenPre, expMiss);
    check(seenAct == !expHit, "R6", "activate only when needed", seenAct, !expHit);
    if (seenAct) begin
      check(actRow == 13'(row), "R4", "activate row", actRow, row);
      check(cyc - actCyc == T_RCD, "R5", "exact activate-to-column", cyc - actCyc, T_RCD);
    end
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : main
    int readyCyc;
    void'($urandom(32'd2024));
    repeat (3) begin
      @(negedge clk);
      check(memCsN && !memCke && !reqReady, "R1", "reset state cs/cke/ready",
            {memCsN, memCke, reqReady}, 3'b100);
    end
    rstN = 1'b1;
    repeat (INIT - 4) @(negedge clk);
    check(memCsN && memCke && !reqReady, "R1", "deselect during settling",
          {memCsN, memCke, reqReady}, 3'b110);
    while (!reqReady) @(negedge clk);
    readyCyc = cyc;
    check(cmdIdx == 3, "R2", "ready only after mode set", cmdIdx, 3);
    check(cyc >= INIT, "R1", "ready not before settling", cyc, INIT);

    doReq(0, 5, 3, 0, 0);      // closed bank
    doReq(0, 5, 7, 1, 0);      // row hit
    doReq(0, 9, 1, 0, 0);      // row conflict
    doReq(1, 100, 1023, 1, 1); // auto-precharge, top column
    doReq(1, 100, 2, 0, 0);    // R8: bank closed again
    doReq(3, 8191, 0, 0, 0);   // top row

    for (int i = 0; i < 300; i++)
      doReq($urandom_range(0, 3), $urandom_range(0, 2) * 4097, $urandom_range(0, 1023),
            1'($urandom_range(0, 1)), $urandom_range(0, 3) == 0);

    repeat (700) @(negedge clk);
    check(refCount - 1 >= (cyc - readyCyc) / REF_I - 1, "R9", "periodic refresh count",
          refCount - 1, (cyc - readyCyc) / REF_I - 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule